// File: doc/BRIEF.md
# Audio Transmitter Host Frame Interface

This block sits between a processor (or a DMA engine) and the serializer of a digital audio transmitter. Software writes each stereo frame as two back-to-back writes to one audio register address. The two words fill a one-frame audio buffer. The per-frame non-audio bits go into a separate holding register, which keeps its value until it is written again. When the serializer pulses `frame_take`, the buffered frame is moved into a registered transmit stage together with the current non-audio bits. The empty flag then sets again, which asks for the next frame.

The block counts the frames the serializer takes, against a programmable block length. It marks the last frame of each block and latches a block-end flag. Two interrupt lines share one priority rule. When the block interrupt enable is set, a pending block end is signalled on the block vector and the empty vector is held back. When that enable is clear, the block end is only seen as an ordinary empty request. A DMA request follows the empty flag alone, so an engine can keep the buffer filled while the core's empty interrupt is disabled.

Register map, selected by `wr_addr`:
- 0 is control. Bit 0 enables the empty interrupt. Bit 1 enables the block interrupt. Writing 1 to bit 2 clears the overrun flag.
- 1 is the non-audio holding register, taking the low NAW bits.
- 2 is the audio data port.
- 3 is the block length minus one, taking the low BLW bits.

Top module: `aud_tx_host`

## Requirements
- R1: After reset, `sts_empty` and `dma_req` are 1. `sts_overrun`, `sts_block`, `irq_empty`, `irq_block`, `tx_valid` and `tx_last` are 0. The transmit words are 0.
- R2: The first write to address 2 leaves `sts_empty` at 1. The second write to address 2 completes the frame and clears `sts_empty` on the next cycle.
- R3: A `frame_take` while a complete frame is buffered loads `tx_left` with the first-written word and `tx_right` with the second. It loads `tx_na` from the non-audio register and sets `tx_valid` to 1. `sts_empty` returns to 1.
- R4: The non-audio register keeps its value across any number of frames until it is written again at address 1.
- R5: A write to address 2 while a complete frame is buffered, with no take in the same cycle, is discarded and sets the sticky `sts_overrun`. Writing control with bit 2 set clears `sts_overrun`.
- R6: `dma_req` equals `sts_empty` whatever the control enables hold.
- R7: `irq_empty` is 1 exactly when `sts_empty` is 1, control bit 0 is set, and no block vector is active.
- R8: Every `frame_take` counts one frame, whether or not the buffer is full. The take that reaches the programmed length sets `tx_last` and `sts_block`. The next take starts a new block.
- R9: With control bit 1 set, a pending block end drives `irq_block` and masks `irq_empty`. With bit 1 clear, `irq_block` stays 0 and the block end shows only through `irq_empty`.
- R10: Completing the next frame's two audio writes clears `sts_block`.
- R11: A `frame_take` with an incomplete buffer sets `tx_valid` to 0 and zero words, and it keeps a partly written word. A take and a write in the same cycle on a full buffer consume the frame and store the write as the new first word, without overrun.
- R12: After reset the block length is 192 frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | DW | Write data |
| frame_take | input | 1 | Serializer moves buffered frame to transmit stage |
| tx_left | output | AW | First audio word of the frame in transmit stage |
| tx_right | output | AW | Second audio word of the frame in transmit stage |
| tx_na | output | NAW | Non-audio bits of the frame in transmit stage |
| tx_valid | output | 1 | Transmit stage holds a complete frame |
| tx_last | output | 1 | Transmit stage frame is last of its block |
| sts_empty | output | 1 | Audio buffer has room for a frame |
| sts_overrun | output | 1 | Sticky: an audio write was discarded |
| sts_block | output | 1 | A block end is pending |
| irq_empty | output | 1 | Empty interrupt vector request |
| irq_block | output | 1 | Block-end interrupt vector request |
| dma_req | output | 1 | DMA request for the next frame |

## Verification
A wrong fill count shows up one cycle after the second audio write. Either `sts_empty` fails to clear, or a later take loads swapped or stale words into `tx_left`/`tx_right`. An off-by-one frame counter moves `tx_last` and `irq_block` one take early or late, so the bench counts takes and compares them with both short programmed blocks and the 192-frame default. A wrong vector priority shows up in the same cycle as a pending block flag, as `irq_empty` and `irq_block` both high or both low.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    typedef enum logic [1:0] {
        REG_CTRL     = 2'd0,
        REG_NONAUDIO = 2'd1,
        REG_AUDIO    = 2'd2,
        REG_BLKLEN   = 2'd3
    } reg_sel_e;

    localparam int CTL_EMPTY_IE = 0;
    localparam int CTL_BLOCK_IE = 1;
    localparam int CTL_OVR_CLR  = 2;

    typedef struct packed {
        logic ctl_wr;
        logic na_wr;
        logic aud_wr;
        logic len_wr;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic en, input logic [1:0] addr);
        wr_dec_t d;
        d.ctl_wr = en && (reg_sel_e'(addr) == REG_CTRL);
        d.na_wr  = en && (reg_sel_e'(addr) == REG_NONAUDIO);
        d.aud_wr = en && (reg_sel_e'(addr) == REG_AUDIO);
        d.len_wr = en && (reg_sel_e'(addr) == REG_BLKLEN);
        return d;
    endfunction

endpackage

// File: rtl/aud_tx_fifo.sv
module aud_tx_fifo #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] wdata,
    input  logic          take,
    input  logic          clr_ovr,
    output logic          full,
    output logic          consume,
    output logic          loaded,
    output logic          overrun,
    output logic [AW-1:0] word0,
    output logic [AW-1:0] word1
);
    logic [1:0]    fill;
    logic [AW-1:0] slot0, slot1;

    assign full    = (fill == 2'd2);
    assign consume = take && full;
    assign loaded  = wr && !consume && (fill == 2'd1);
    assign word0   = slot0;
    assign word1   = slot1;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill    <= 2'd0;
            slot0   <= '0;
            slot1   <= '0;
            overrun <= 1'b0;
        end else begin
            if (consume) begin
                if (wr) begin
                    slot0 <= wdata;
                    fill  <= 2'd1;
                end else begin
                    fill  <= 2'd0;
                end
            end else if (wr) begin
                if (fill == 2'd0) begin
                    slot0 <= wdata;
                    fill  <= 2'd1;
                end else if (fill == 2'd1) begin
                    slot1 <= wdata;
                    fill  <= 2'd2;
                end
            end
            if (wr && full && !take)
                overrun <= 1'b1;
            else if (clr_ovr)
                overrun <= 1'b0;
        end
    end

    assert_empty_after_take_R3: assert property (@(posedge clk) disable iff (rst)
        consume |=> !full);
    assert_second_word_fills_R2: assert property (@(posedge clk) disable iff (rst)
        (fill == 2'd1 && wr) |=> full);
    assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (overrun && !clr_ovr) |=> overrun);
    assert_discard_keeps_words_R5: assert property (@(posedge clk) disable iff (rst)
        (wr && full && !take) |=> ($stable(slot0) && $stable(slot1)));
endmodule

// File: rtl/aud_tx_blkcnt.sv
module aud_tx_blkcnt #(
    parameter int BLW        = 8,
    parameter int BLK_FRAMES = 192
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           len_wr,
    input  logic [BLW-1:0] len_data,
    input  logic           take,
    output logic           last,
    output logic           block_end
);
    localparam logic [BLW-1:0] LEN_M1_RST = BLW'(BLK_FRAMES - 1);

    logic [BLW-1:0] len_m1;
    logic [BLW-1:0] cnt;

    assign last      = (cnt >= len_m1);
    assign block_end = take && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_m1 <= LEN_M1_RST;
            cnt    <= '0;
        end else begin
            if (len_wr)
                len_m1 <= len_data;
            if (take)
                cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    assert_wrap_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        block_end |=> (cnt == '0));
    assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
        (take && !last) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/aud_tx_irq.sv
module aud_tx_irq (
    input  logic clk,
    input  logic rst,
    input  logic ctl_wr,
    input  logic empty_ie_d,
    input  logic block_ie_d,
    input  logic block_end,
    input  logic loaded,
    input  logic empty,
    output logic block_flag,
    output logic irq_empty,
    output logic irq_block,
    output logic dma_req
);
    logic empty_ie, block_ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_ie   <= 1'b0;
            block_ie   <= 1'b0;
            block_flag <= 1'b0;
        end else begin
            if (ctl_wr) begin
                empty_ie <= empty_ie_d;
                block_ie <= block_ie_d;
            end
            if (block_end)
                block_flag <= 1'b1;
            else if (loaded)
                block_flag <= 1'b0;
        end
    end

    assign irq_block = block_ie && block_flag;
    assign irq_empty = empty_ie && empty && !irq_block;
    assign dma_req   = empty;

    assert_block_vector_R9: assert property (@(posedge clk) disable iff (rst)
        (block_end && block_ie && !ctl_wr) |=> irq_block);
    assert_fallback_vector_R9: assert property (@(posedge clk) disable iff (rst)
        (block_end && !block_ie && empty_ie && !ctl_wr && !loaded) |=> irq_empty);
    assert_block_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (loaded && !block_end) |=> !block_flag);
endmodule

// File: rtl/aud_tx_host.sv
module aud_tx_host
    import aud_tx_pkg::*;
#(
    parameter int DW         = 24,
    parameter int AW         = 24,
    parameter int NAW        = 4,
    parameter int BLW        = 8,
    parameter int BLK_FRAMES = 192
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [1:0]     wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic           frame_take,
    output logic [AW-1:0]  tx_left,
    output logic [AW-1:0]  tx_right,
    output logic [NAW-1:0] tx_na,
    output logic           tx_valid,
    output logic           tx_last,
    output logic           sts_empty,
    output logic           sts_overrun,
    output logic           sts_block,
    output logic           irq_empty,
    output logic           irq_block,
    output logic           dma_req
);
    wr_dec_t        dec;
    logic           full, consume, loaded, last, block_end;
    logic [AW-1:0]  word0, word1;
    logic [NAW-1:0] na_reg;

    assign dec       = decode_write(wr_en, wr_addr);
    assign sts_empty = !full;

    aud_tx_fifo #(.AW(AW)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr      (dec.aud_wr),
        .wdata   (wr_data[AW-1:0]),
        .take    (frame_take),
        .clr_ovr (dec.ctl_wr && wr_data[CTL_OVR_CLR]),
        .full    (full),
        .consume (consume),
        .loaded  (loaded),
        .overrun (sts_overrun),
        .word0   (word0),
        .word1   (word1)
    );

    aud_tx_blkcnt #(.BLW(BLW), .BLK_FRAMES(BLK_FRAMES)) u_blkcnt (
        .clk       (clk),
        .rst       (rst),
        .len_wr    (dec.len_wr),
        .len_data  (wr_data[BLW-1:0]),
        .take      (frame_take),
        .last      (last),
        .block_end (block_end)
    );

    aud_tx_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (dec.ctl_wr),
        .empty_ie_d (wr_data[CTL_EMPTY_IE]),
        .block_ie_d (wr_data[CTL_BLOCK_IE]),
        .block_end  (block_end),
        .loaded     (loaded),
        .empty      (sts_empty),
        .block_flag (sts_block),
        .irq_empty  (irq_empty),
        .irq_block  (irq_block),
        .dma_req    (dma_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            na_reg   <= '0;
            tx_left  <= '0;
            tx_right <= '0;
            tx_na    <= '0;
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
        end else begin
            if (dec.na_wr)
                na_reg <= wr_data[NAW-1:0];
            if (frame_take) begin
                tx_left  <= consume ? word0 : '0;
                tx_right <= consume ? word1 : '0;
                tx_na    <= na_reg;
                tx_valid <= consume;
                tx_last  <= last;
            end
        end
    end

    assert_take_sets_valid_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_take && full) |=> (tx_valid && sts_empty));
    assert_partial_take_R11: assert property (@(posedge clk) disable iff (rst)
        (frame_take && !full) |=> (!tx_valid && tx_left == '0));
    assert_last_marks_block_R8: assert property (@(posedge clk) disable iff (rst)
        (frame_take && last) |=> (tx_last && sts_block));
    assert_vectors_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(irq_empty && irq_block));
    assert_dma_no_frame_R6: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> !full);
endmodule

// File: tb/aud_tx_host_bench.sv
module aud_tx_host_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [23:0] wr_data = '0;
    logic        frame_take = 1'b0;
    logic [23:0] tx_left, tx_right;
    logic [3:0]  tx_na;
    logic        tx_valid, tx_last, sts_empty, sts_overrun, sts_block;
    logic        irq_empty, irq_block, dma_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    aud_tx_host u_aud_tx_host (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_take(frame_take), .tx_left(tx_left), .tx_right(tx_right), .tx_na(tx_na),
        .tx_valid(tx_valid), .tx_last(tx_last), .sts_empty(sts_empty),
        .sts_overrun(sts_overrun), .sts_block(sts_block), .irq_empty(irq_empty),
        .irq_block(irq_block), .dma_req(dma_req)
    );

    typedef struct packed {
        logic        is_take;
        logic [1:0]  addr;
        logic [23:0] data;
        logic        e_empty;
        logic        e_ovr;
        logic        e_irqe;
        logic        e_dma;
        logic        e_valid;
        logic [23:0] e_left;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 24'h000001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 24'h000000},
        '{1'b0, 2'd1, 24'h000005, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 24'h000000},
        '{1'b0, 2'd2, 24'h111111, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 24'h000000},
        '{1'b0, 2'd2, 24'h222222, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h000000},
        '{1'b0, 2'd2, 24'h333333, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 24'h000000},
        '{1'b1, 2'd0, 24'h000000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 24'h111111},
        '{1'b0, 2'd0, 24'h000004, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 24'h111111},
        '{1'b0, 2'd2, 24'hAAAAAA, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 24'h111111},
        '{1'b1, 2'd0, 24'h000000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 24'h000000},
        '{1'b0, 2'd2, 24'hBBBBBB, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h000000},
        '{1'b1, 2'd0, 24'h000000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 24'hAAAAAA}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; frame_take = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cycle(input logic w, input logic [1:0] a, input logic [23:0] d, input logic t);
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; frame_take = t;
        @(negedge clk);
        wr_en = 1'b0; frame_take = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        cycle(1'b1, a, d, 1'b0);
    endtask

    task automatic take();
        cycle(1'b0, 2'd0, 24'h0, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 empty", {31'd0, sts_empty}, 32'd1);
        chk("R1 dma", {31'd0, dma_req}, 32'd1);
        chk("R1 flags", {28'd0, sts_overrun, sts_block, irq_empty, irq_block}, 32'd0);
        chk("R1 tx", {tx_left[7:0], tx_right[7:0], 6'd0, tx_valid, tx_last, 4'd0, tx_na}, 32'd0);

        // Table walk: R2 R3 R5 R6 R7 R11
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_take) take();
            else wr(VECS[i].addr, VECS[i].data);
            chk($sformatf("R2 R3 empty vec%0d", i), {31'd0, sts_empty}, {31'd0, VECS[i].e_empty});
            chk($sformatf("R5 overrun vec%0d", i), {31'd0, sts_overrun}, {31'd0, VECS[i].e_ovr});
            chk($sformatf("R7 irq_empty vec%0d", i), {31'd0, irq_empty}, {31'd0, VECS[i].e_irqe});
            chk($sformatf("R6 dma vec%0d", i), {31'd0, dma_req}, {31'd0, VECS[i].e_dma});
            chk($sformatf("R3 R11 valid vec%0d", i), {31'd0, tx_valid}, {31'd0, VECS[i].e_valid});
            chk($sformatf("R3 R11 left vec%0d", i), {8'd0, tx_left}, {8'd0, VECS[i].e_left});
        end
        chk("R3 right word", {8'd0, tx_right}, 32'h00BBBBBB);
        chk("R4 na carried", {28'd0, tx_na}, 32'd5);

        // R8 R9 R10 R4: three-frame blocks with block vector enabled
        do_reset();
        wr(2'd3, 24'd2);
        wr(2'd0, 24'd3);
        wr(2'd1, 24'd9);
        for (int f = 1; f <= 3; f++) begin
            wr(2'd2, 24'h000100 + 24'(f));
            wr(2'd2, 24'h000200 + 24'(f));
            take();
            chk($sformatf("R4 na frame%0d", f), {28'd0, tx_na}, 32'd9);
            chk($sformatf("R8 last frame%0d", f), {31'd0, tx_last}, (f == 3) ? 32'd1 : 32'd0);
            chk($sformatf("R9 irq_block frame%0d", f), {31'd0, irq_block}, (f == 3) ? 32'd1 : 32'd0);
            chk($sformatf("R9 irq_empty frame%0d", f), {31'd0, irq_empty}, (f == 3) ? 32'd0 : 32'd1);
        end
        chk("R8 block flag", {31'd0, sts_block}, 32'd1);
        wr(2'd2, 24'h000AAA);
        chk("R10 flag after one word", {31'd0, sts_block}, 32'd1);
        wr(2'd2, 24'h000BBB);
        chk("R10 flag cleared", {31'd0, sts_block}, 32'd0);
        chk("R10 irq_block cleared", {31'd0, irq_block}, 32'd0);

        // R9 fallback with block vector disabled; counter wrapped R8
        wr(2'd0, 24'd1);
        take();
        take();
        chk("R8 no early last", {31'd0, tx_last}, 32'd0);
        take();
        chk("R8 wrap last", {31'd0, tx_last}, 32'd1);
        chk("R9 no block vector", {31'd0, irq_block}, 32'd0);
        chk("R9 fallback empty vector", {31'd0, irq_empty}, 32'd1);
        chk("R9 flag pending", {31'd0, sts_block}, 32'd1);

        // R11 simultaneous take and write on full buffer
        do_reset();
        wr(2'd2, 24'h000011);
        wr(2'd2, 24'h000022);
        cycle(1'b1, 2'd2, 24'h000033, 1'b1);
        chk("R11 no overrun", {31'd0, sts_overrun}, 32'd0);
        chk("R11 consumed left", {8'd0, tx_left}, 32'h00000011);
        chk("R11 still empty", {31'd0, sts_empty}, 32'd1);
        wr(2'd2, 24'h000044);
        take();
        chk("R11 new first word", {8'd0, tx_left}, 32'h00000033);
        chk("R11 new second word", {8'd0, tx_right}, 32'h00000044);

        // R12 default block length of 192
        do_reset();
        begin
            int early = 0;
            for (int k = 1; k < 192; k++) begin
                take();
                if (tx_last) early++;
            end
            chk("R12 no last before 192", early, 32'd0);
            take();
            chk("R12 last at 192", {31'd0, tx_last}, 32'd1);
        end

        finish_run();
    end
endmodule